// File: doc/BRIEF.md
# Replay FIFO with Half-Level Flag

This block is a single-clock first-in/first-out buffer for 9-bit words. Software or a neighbouring block puts a word in by holding the write strobe low for one clock. It takes the oldest word out by holding the read strobe low for one clock. No address is supplied from outside. Two internal ring pointers track the next storage location to fill and the next one to drain, and both wrap round the storage. The ninth bit is free for parity or a control marker.

Three active-low flags report the fill state: empty, full, and more-than-half-full. Each strobe is guarded by its flag. A write is refused while the buffer is full, and a read is refused while it is empty. A read and a write may be accepted in the same clock.

An active-low replay input sends the read pointer back to storage location zero and leaves the write pointer where it is. Everything written since reset can then be read out a second time. An active-low reset clears both pointers at any moment.

The depth is a parameter: 256, 512 or 1024 words. Both strobes are sampled as synchronous enables on the rising clock edge.

Top module: `fifo_rt`

## Requirements
- R1: While `rst_n` is low, both pointers return to location zero and `rd_data` clears to 0. At the first edge after release, `empty_n` reads 0, `full_n` reads 1 and `half_n` reads 1.
- R2: Words taken in with `wr_n` low come out in the same order. `rd_data` takes the popped word at the rising edge where a read is accepted, and keeps its value in every other cycle.
- R3: A write strobe while `full_n` is 0 stores nothing. The level stays at DEPTH, and the words already stored are read out unchanged.
- R4: A read strobe while `empty_n` is 0 leaves `rd_data` and the read pointer unchanged. This holds even when a write is accepted in the same cycle.
- R5: When neither flag blocks, a read and a write in the same cycle are both accepted, and the stored level does not change.
- R6: `full_n` is 0 exactly when the stored level equals DEPTH, and `empty_n` is 0 exactly when the level is 0.
- R7: `half_n` is 0 exactly when the stored level is greater than DEPTH/2. With the default depth, that means 129 or more words.
- R8: A cycle with `rtx_n` low and `rst_n` high does three things. It sets the read pointer to location zero, leaves the write pointer unchanged, and sets the level to the write pointer's location, so all flags follow the new level. Strobes in that cycle are ignored. The words are then replayed from the first word written after reset, provided fewer than DEPTH writes have happened since reset.
- R9: Both pointers wrap from location DEPTH-1 to location zero, and ordering is preserved across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of both pointers and the level |
| wr_n | input | 1 | Active-low write strobe, sampled at the rising edge |
| rd_n | input | 1 | Active-low read strobe, sampled at the rising edge |
| rtx_n | input | 1 | Active-low replay: rewinds the read pointer to location zero |
| wr_data | input | 9 | Word to store |
| rd_data | output | 9 | Last word popped, registered |
| empty_n | output | 1 | Low when no word is stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |

## Verification
Several behaviours are checked on every cycle:
- a write is refused at full and a read is refused at empty;
- the output word holds across refused reads and replay cycles;
- full implies more than half;
- the flags are stable during an accepted simultaneous read and write;
- a write into an empty buffer clears empty.

Some behaviours can only be shown by the bench's scenarios, because each needs a reference model of the stored words:
- the word order;
- exactly where the half-level threshold sits;
- that replay restarts at the first word written;
- that storage stays correct across the pointer wrap.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;

   typedef struct packed {
      logic empty_n;
      logic full_n;
      logic half_n;
   } fifo_flags_t;

   function automatic bit depth_supported(input int unsigned d);
      return (d == 256) || (d == 512) || (d == 1024);
   endfunction

endpackage

// File: rtl/fifo_rt_ptr.sv
module fifo_rt_ptr #(
   parameter int unsigned AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rewind,
   input  logic          advance,
   output logic [AW-1:0] addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr <= '0;
      else if (rewind)
         addr <= '0;
      else if (advance)
         addr <= addr + AW'(1);
   end
endmodule

// File: rtl/fifo_rt_mem.sv
module fifo_rt_mem #(
   parameter int unsigned WIDTH = 9,
   parameter int unsigned DEPTH = 256,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             re,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] words [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      always_ff @(posedge clk) begin
         if (we && (waddr == AW'(i)))
            words[i] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (re)
         rdata <= words[raddr];
   end
endmodule

// File: rtl/fifo_rt_level.sv
module fifo_rt_level #(
   parameter int unsigned DEPTH = 256,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = AW + 1,
   localparam int unsigned HALF = DEPTH / 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      push,
   input  logic                      pop,
   input  logic                      rewind,
   input  logic [AW-1:0]             wr_addr,
   output fifo_rt_pkg::fifo_flags_t  flags
);
   logic [CW-1:0] level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         level <= '0;
      else if (rewind)
         level <= {1'b0, wr_addr};
      else if (push && !pop)
         level <= level + CW'(1);
      else if (pop && !push)
         level <= level - CW'(1);
   end

   always_comb begin
      flags.empty_n = (level != '0);
      flags.full_n  = (level != CW'(DEPTH));
      flags.half_n  = !(level > CW'(HALF));
   end
endmodule

// File: rtl/fifo_rt.sv
module fifo_rt #(
   parameter int unsigned WIDTH = 9,
   parameter int unsigned DEPTH = 256,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_n,
   input  logic             rd_n,
   input  logic             rtx_n,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] rd_data,
   output logic             empty_n,
   output logic             full_n,
   output logic             half_n
);
   import fifo_rt_pkg::*;

   if (!depth_supported(DEPTH)) begin : g_bad_depth
      $error("fifo_rt: DEPTH must be 256, 512 or 1024");
   end
   if (WIDTH != 9) begin : g_bad_width
      $error("fifo_rt: WIDTH must be 9");
   end

   fifo_flags_t   flags;
   logic [AW-1:0] waddr;
   logic [AW-1:0] raddr;
   logic          rewind;
   logic          push;
   logic          pop;

   assign rewind = !rtx_n;
   assign push   = !wr_n && flags.full_n  && !rewind;
   assign pop    = !rd_n && flags.empty_n && !rewind;

   fifo_rt_ptr #(.AW(AW)) u_wptr (
      .clk(clk), .rst_n(rst_n), .rewind(1'b0), .advance(push), .addr(waddr)
   );

   fifo_rt_ptr #(.AW(AW)) u_rptr (
      .clk(clk), .rst_n(rst_n), .rewind(rewind), .advance(pop), .addr(raddr)
   );

   fifo_rt_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
      .clk(clk), .rst_n(rst_n), .we(push), .waddr(waddr), .wdata(wr_data),
      .re(pop), .raddr(raddr), .rdata(rd_data)
   );

   fifo_rt_level #(.DEPTH(DEPTH)) u_level (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .rewind(rewind),
      .wr_addr(waddr), .flags(flags)
   );

   assign empty_n = flags.empty_n;
   assign full_n  = flags.full_n;
   assign half_n  = flags.half_n;
endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk #(
   parameter int unsigned WIDTH = 9,
   parameter int unsigned DEPTH = 256
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_n,
   input logic             rd_n,
   input logic             rtx_n,
   input logic [WIDTH-1:0] rd_data,
   input logic             empty_n,
   input logic             full_n,
   input logic             half_n
);
   AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!empty_n && full_n && half_n && rd_data == '0)); // R1

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_n && !wr_n && rd_n && rtx_n) |=> !full_n); // R3

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty_n && !rd_n) |=> $stable(rd_data)); // R4

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_n && $past(rst_n)) |=> $stable(rd_data)); // R2

   AST_BOTH_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_n && full_n && !wr_n && !rd_n && rtx_n)
         |=> $stable({empty_n, full_n, half_n})); // R5

   AST_FULL_ABOVE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n |-> !half_n); // R7

   AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty_n && !wr_n && rtx_n) |=> empty_n); // R6

   AST_RETX_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !rtx_n |=> $stable(rd_data)); // R8
endmodule

bind fifo_rt fifo_rt_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rtx_n(rtx_n),
   .rd_data(rd_data), .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
);

// File: tb/tb_fifo_rt.sv
module tb_fifo_rt;
   localparam int DEPTH = 256;
   localparam int NVEC  = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_n = 1'b1;
   logic       rd_n = 1'b1;
   logic       rtx_n = 1'b1;
   logic [8:0] wr_data = '0;
   logic [8:0] rd_data;
   logic       empty_n, full_n, half_n;

   int checks = 0;
   int errors = 0;

   logic [8:0] hist [4096];
   int         widx, ridx;
   logic [8:0] m_dout;

   always #4 clk = ~clk;

   fifo_rt #(.WIDTH(9), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rtx_n(rtx_n),
      .wr_data(wr_data), .rd_data(rd_data),
      .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
   );

   // vector: op[22:21] (0 idle, 1 write, 2 read, 3 both), din[20:12],
   //         expected dout[11:3], expected {empty_n, full_n, half_n}[2:0]
   localparam logic [22:0] VEC [NVEC] = '{
      {2'd2, 9'h000, 9'h000, 3'b011},
      {2'd1, 9'h101, 9'h000, 3'b111},
      {2'd1, 9'h0A5, 9'h000, 3'b111},
      {2'd3, 9'h1FF, 9'h101, 3'b111},
      {2'd2, 9'h000, 9'h0A5, 3'b111},
      {2'd2, 9'h000, 9'h1FF, 3'b011},
      {2'd2, 9'h000, 9'h1FF, 3'b011},
      {2'd3, 9'h055, 9'h1FF, 3'b111},
      {2'd0, 9'h000, 9'h1FF, 3'b111},
      {2'd2, 9'h000, 9'h055, 3'b011}
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rtx_n = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      widx = 0; ridx = 0; m_dout = '0;
   endtask

   // one cycle; model updated from the pre-edge state
   task automatic cyc(input bit w, input bit r, input bit rt, input logic [8:0] d);
      int lvl;
      wr_n = !w; rd_n = !r; rtx_n = !rt; wr_data = d;
      @(posedge clk);
      lvl = widx - ridx;
      if (rt) begin
         ridx = 0;
      end else begin
         if (r && lvl > 0) begin m_dout = hist[ridx]; ridx++; end
         if (w && lvl < DEPTH) begin hist[widx] = d; widx++; end
      end
      @(negedge clk);
      wr_n = 1'b1; rd_n = 1'b1; rtx_n = 1'b1;
   endtask

   task automatic chk_all(input string tag);
      int lvl;
      lvl = widx - ridx;
      chk({tag, " dout"}, rd_data, m_dout);
      chk({tag, " empty_n"}, empty_n, lvl != 0);
      chk({tag, " full_n"}, full_n, lvl != DEPTH);
      chk({tag, " half_n"}, half_n, !(lvl > DEPTH/2));
   endtask

   function automatic logic [8:0] pat(input int i);
      return 9'((i * 37 + 5) & 9'h1FF);
   endfunction

   initial begin
      widx = 0; ridx = 0; m_dout = '0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset dout", rd_data, 0);
      chk("R1 reset empty_n", empty_n, 0);
      chk("R1 reset full_n", full_n, 1);
      chk("R1 reset half_n", half_n, 1);

      // vector walk: R2 ordering, R4 underflow, R5 simultaneous
      for (int v = 0; v < NVEC; v++) begin
         wr_n = !VEC[v][21]; rd_n = !VEC[v][22]; wr_data = VEC[v][20:12];
         @(posedge clk);
         @(negedge clk);
         wr_n = 1'b1; rd_n = 1'b1;
         chk($sformatf("R2 R4 R5 vec%0d dout", v), rd_data, VEC[v][11:3]);
         chk($sformatf("R2 R4 R5 vec%0d flags", v), {empty_n, full_n, half_n}, VEC[v][2:0]);
      end

      // fill to full, half threshold: R6, R7
      do_reset();
      for (int i = 0; i < DEPTH; i++) begin
         cyc(1, 0, 0, pat(i));
         if (i == DEPTH/2 - 1 || i == DEPTH/2 || i == DEPTH - 2 || i == DEPTH - 1)
            chk_all($sformatf("R6 R7 fill%0d", i + 1));
      end
      // overflow attempt: R3
      cyc(1, 0, 0, 9'h1EE);
      chk_all("R3 overflow");
      // drain fully: R2, R7 on the way down
      for (int i = 0; i < DEPTH; i++) begin
         cyc(0, 1, 0, '0);
         chk_all($sformatf("R2 R7 drain%0d", i));
      end
      // underflow with concurrent write: R4
      cyc(1, 1, 0, 9'h0C3);
      chk_all("R4 underflow with write");
      cyc(0, 1, 0, '0);
      chk_all("R4 after underflow");
      // wrap around the ring: R9
      for (int i = 0; i < 20; i++) cyc(1, 0, 0, pat(i + 500));
      for (int i = 0; i < 20; i++) begin
         cyc(0, 1, 0, '0);
         chk_all($sformatf("R9 wrap%0d", i));
      end

      // retransmit with strobes in the same cycle: R8
      do_reset();
      for (int i = 0; i < 5; i++) cyc(1, 0, 0, pat(i + 100));
      cyc(0, 1, 0, '0);
      cyc(0, 1, 0, '0);
      chk_all("R8 before replay");
      cyc(1, 1, 1, 9'h111);
      chk_all("R8 replay cycle");
      for (int i = 0; i < 5; i++) begin
         cyc(0, 1, 0, '0);
         chk_all($sformatf("R8 replay%0d", i));
      end
      chk("R8 strobe during replay ignored", empty_n, 0);

      // replay after draining a large block: R8 with half level, R7
      do_reset();
      for (int i = 0; i < 200; i++) cyc(1, 0, 0, pat(i + 7));
      for (int i = 0; i < 200; i++) cyc(0, 1, 0, '0);
      chk_all("R8 drained");
      cyc(0, 0, 1, '0);
      chk_all("R8 R7 rewound level");
      for (int i = 0; i < 200; i++) begin
         cyc(0, 1, 0, '0);
         if (i < 3 || i > 196) chk_all($sformatf("R8 big replay%0d", i));
      end

      // reset in the middle of traffic: R1
      cyc(1, 0, 0, 9'h0F0);
      cyc(1, 0, 0, 9'h0F1);
      do_reset();
      @(negedge clk);
      chk_all("R1 reset mid traffic");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule